// File: doc/BRIEF.md
# Framed Command Packet Receiver

This block sits behind a serial byte receiver and pulls framed command messages out of the incoming byte stream. While it waits for a frame it drops every byte except the start marker. Once it sees the start marker it collects a client-type byte, a length byte and a multi-byte target address. It then passes the payload bytes downstream as they arrive, over a valid/ready handshake. Last, it checks a CRC byte and a closing marker.

The captured header is presented with a one-cycle `hdr_valid` strobe just before the payload begins. The verdict on the frame comes later, as a one-cycle `frame_ok` or `frame_error` pulse. Payload bytes are never held back waiting for the verdict, so a consumer that commits side effects must buffer them until `frame_ok`, or discard them on `frame_error`.

Top module: `frm_rx_top`

## Requirements
- R1: After reset the block is waiting for a frame: `in_ready`=1, `out_valid`=0, and `hdr_valid`, `frame_ok` and `frame_error` are all 0.
- R2: While waiting for a frame, any accepted byte other than 0x3C is dropped. It produces no payload beat, no header strobe and no status pulse.
- R3: The frame after 0x3C is laid out as type byte, length byte, then the address (3 bytes, most significant byte first). `hdr_valid` pulses for one cycle, in the cycle after the last address byte is accepted. In that cycle `hdr_type`, `hdr_addr` and `hdr_count` hold the received values.
- R4: The length byte L announces L+1 payload bytes (0x00 means 1 byte, 0xFF means 256 bytes), and `hdr_count` = L+1. Exactly L+1 bytes are forwarded on `out_data`, in arrival order, and `out_valid` is never high outside the payload.
- R5: During the payload `in_ready` follows `out_ready`. A payload byte offered while `out_ready`=0 is held upstream and is neither lost nor duplicated.
- R6: The byte after the payload is compared against a CRC-8 with polynomial 0x07 (x^8+x^2+x+1), initial value 0x00, MSB first and no final XOR. The CRC covers the type byte through the last payload byte.
- R7: If the CRC matches and the next byte is 0xA5, `frame_ok` pulses for one cycle, in the cycle after that byte is accepted.
- R8: A CRC mismatch pulses `frame_error` for one cycle, in the cycle after the CRC byte is accepted. The receiver then waits for a new 0x3C, so a following 0xA5 is dropped.
- R9: A byte other than 0xA5 in the end-marker position pulses `frame_error` for one cycle, in the cycle after it is accepted, and the receiver returns to waiting.
- R10: `frame_ok` and `frame_error` are never high together. Payload lengths of 1 and 256 bytes are both received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Incoming byte is valid |
| in_data | input | 8 | Incoming byte |
| in_ready | output | 1 | Block accepts the incoming byte |
| out_valid | output | 1 | Payload byte valid |
| out_data | output | 8 | Payload byte |
| out_ready | input | 1 | Downstream accepts the payload byte |
| hdr_valid | output | 1 | One-cycle strobe: header fields are valid |
| hdr_type | output | 8 | Client type byte |
| hdr_addr | output | 24 | Target address |
| hdr_count | output | 9 | Payload byte count (1 to 256) |
| frame_ok | output | 1 | One-cycle pulse: frame passed CRC and end-marker checks |
| frame_error | output | 1 | One-cycle pulse: frame rejected |

## Verification
The checker watches every cycle for the following:
- the status and header strobes are single-cycle pulses;
- `frame_ok` and `frame_error` never coincide;
- `frame_ok` is always preceded by an accepted 0xA5;
- a payload beat never goes past the announced count;
- `in_ready` is withheld whenever a payload byte is stalled.

The directed scenarios are needed for the rest:
- the exact header values and address byte order;
- the payload contents and order under backpressure;
- the CRC arithmetic;
- recovery from a rejected frame;
- dropping of bytes outside a frame;
- the 1-byte and 256-byte length extremes.

// File: rtl/frm_rx_pkg.sv
package frm_rx_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] MARK_OPEN  = 8'h3C;
  localparam logic [BYTE_W-1:0] MARK_CLOSE = 8'hA5;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_TYPE,
    ST_LEN,
    ST_ADDR,
    ST_BODY,
    ST_CHECK,
    ST_CLOSE
  } rx_state_e;

  // One byte of a CRC-8, MSB first, no reflection
  function automatic logic [BYTE_W-1:0] crc8_next(
    input logic [BYTE_W-1:0] cur,
    input logic [BYTE_W-1:0] din,
    input logic [BYTE_W-1:0] poly
  );
    logic [BYTE_W-1:0] r;
    r = cur ^ din;
    for (int k = 0; k < BYTE_W; k++) begin
      if (r[BYTE_W-1]) r = (r << 1) ^ poly;
      else             r = r << 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/frm_rst_sync.sv
module frm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/frm_crc8.sv
module frm_crc8
  import frm_rx_pkg::*;
#(
  parameter logic [BYTE_W-1:0] POLY = 8'h07,
  parameter logic [BYTE_W-1:0] SEED = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] crc
);
  logic [BYTE_W-1:0] crc_q, crc_d;
  logic              crc_we;

  always_comb begin
    crc_we = clr | en;
    crc_d  = clr ? SEED : crc8_next(crc_q, din, POLY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= SEED;
    else if (crc_we) crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/frm_hdr_regs.sv
module frm_hdr_regs
  import frm_rx_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 3,
  localparam int unsigned ADDR_W    = ADDR_BYTES * BYTE_W,
  localparam int unsigned CNT_W     = BYTE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_type,
  input  logic              cap_len,
  input  logic              cap_addr,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] type_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [BYTE_W-1:0] type_q;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  count_q, count_d;

  generate
    if (ADDR_BYTES > 1) begin : g_shift
      always_comb addr_d = {addr_q[ADDR_W-BYTE_W-1:0], din};
    end else begin : g_single
      always_comb addr_d = din;
    end
  endgenerate

  always_comb count_d = {1'b0, din} + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q  <= '0;
      addr_q  <= '0;
      count_q <= '0;
    end else begin
      if (cap_type) type_q  <= din;
      if (cap_len)  count_q <= count_d;
      if (cap_addr) addr_q  <= addr_d;
    end
  end

  assign type_o  = type_q;
  assign addr_o  = addr_q;
  assign count_o = count_q;
endmodule

// File: rtl/frm_rx_fsm.sv
module frm_rx_fsm
  import frm_rx_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 3,
  localparam int unsigned IDX_W     = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  input  logic [BYTE_W-1:0] crc_val,
  output logic              crc_clr,
  output logic              crc_en,
  output logic              cap_type,
  output logic              cap_len,
  output logic              cap_addr,
  output logic              hdr_valid,
  output logic              frame_ok,
  output logic              frame_error
);
  rx_state_e         state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [BYTE_W-1:0] rem_q, rem_d;
  logic              hdr_q, hdr_d;
  logic              ok_q, ok_d;
  logic              err_q, err_d;
  logic              take;

  always_comb begin
    in_ready  = (state_q == ST_BODY) ? out_ready : 1'b1;
    out_valid = (state_q == ST_BODY) & in_valid;
    take      = in_valid & in_ready;
  end

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    rem_d    = rem_q;
    hdr_d    = 1'b0;
    ok_d     = 1'b0;
    err_d    = 1'b0;
    crc_clr  = 1'b0;
    crc_en   = 1'b0;
    cap_type = 1'b0;
    cap_len  = 1'b0;
    cap_addr = 1'b0;
    if (take) begin
      unique case (state_q)
        ST_HUNT: begin
          if (in_data == MARK_OPEN) begin
            crc_clr = 1'b1;
            state_d = ST_TYPE;
          end
        end
        ST_TYPE: begin
          cap_type = 1'b1;
          crc_en   = 1'b1;
          state_d  = ST_LEN;
        end
        ST_LEN: begin
          cap_len = 1'b1;
          crc_en  = 1'b1;
          rem_d   = in_data;
          idx_d   = '0;
          state_d = ST_ADDR;
        end
        ST_ADDR: begin
          cap_addr = 1'b1;
          crc_en   = 1'b1;
          if (idx_q == IDX_W'(ADDR_BYTES - 1)) begin
            hdr_d   = 1'b1;
            state_d = ST_BODY;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
        ST_BODY: begin
          crc_en = 1'b1;
          if (rem_q == '0) state_d = ST_CHECK;
          else             rem_d   = rem_q - BYTE_W'(1);
        end
        ST_CHECK: begin
          if (in_data != crc_val) begin
            err_d   = 1'b1;
            state_d = ST_HUNT;
          end else begin
            state_d = ST_CLOSE;
          end
        end
        ST_CLOSE: begin
          if (in_data == MARK_CLOSE) ok_d  = 1'b1;
          else                       err_d = 1'b1;
          state_d = ST_HUNT;
        end
        default: state_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      idx_q   <= '0;
      rem_q   <= '0;
      hdr_q   <= 1'b0;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      rem_q   <= rem_d;
      hdr_q   <= hdr_d;
      ok_q    <= ok_d;
      err_q   <= err_d;
    end
  end

  assign hdr_valid   = hdr_q;
  assign frame_ok    = ok_q;
  assign frame_error = err_q;
endmodule

// File: rtl/frm_rx_top.sv
module frm_rx_top
  import frm_rx_pkg::*;
#(
  parameter int unsigned       ADDR_BYTES = 3,
  parameter logic [BYTE_W-1:0] CRC_POLY   = 8'h07,
  parameter logic [BYTE_W-1:0] CRC_SEED   = 8'h00,
  localparam int unsigned      ADDR_W     = ADDR_BYTES * BYTE_W,
  localparam int unsigned      CNT_W      = BYTE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  input  logic              out_ready,
  output logic              hdr_valid,
  output logic [BYTE_W-1:0] hdr_type,
  output logic [ADDR_W-1:0] hdr_addr,
  output logic [CNT_W-1:0]  hdr_count,
  output logic              frame_ok,
  output logic              frame_error
);
  logic              rst_n_int;
  logic [BYTE_W-1:0] crc_val;
  logic              crc_clr, crc_en;
  logic              cap_type, cap_len, cap_addr;

  frm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  frm_rx_fsm #(.ADDR_BYTES(ADDR_BYTES)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .crc_val     (crc_val),
    .crc_clr     (crc_clr),
    .crc_en      (crc_en),
    .cap_type    (cap_type),
    .cap_len     (cap_len),
    .cap_addr    (cap_addr),
    .hdr_valid   (hdr_valid),
    .frame_ok    (frame_ok),
    .frame_error (frame_error)
  );

  frm_crc8 #(.POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
    .clk   (clk),
    .rst_n (rst_n_int),
    .clr   (crc_clr),
    .en    (crc_en),
    .din   (in_data),
    .crc   (crc_val)
  );

  frm_hdr_regs #(.ADDR_BYTES(ADDR_BYTES)) u_hdr (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .cap_type (cap_type),
    .cap_len  (cap_len),
    .cap_addr (cap_addr),
    .din      (in_data),
    .type_o   (hdr_type),
    .addr_o   (hdr_addr),
    .count_o  (hdr_count)
  );

  assign out_data = in_data;
endmodule

// File: rtl/frm_rx_top_chk.sv
module frm_rx_top_chk #(
  parameter int unsigned CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [7:0]       in_data,
  input logic             out_valid,
  input logic             out_ready,
  input logic             hdr_valid,
  input logic [CNT_W-1:0] hdr_count,
  input logic             frame_ok,
  input logic             frame_error
);
  logic [CNT_W:0] budget_q;
  logic           beat;

  assign beat = out_valid & out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         budget_q <= '0;
    else if (hdr_valid)                 budget_q <= {1'b0, hdr_count} - {{CNT_W{1'b0}}, beat};
    else if (beat && budget_q != '0)    budget_q <= budget_q - 1'b1;
  end

  // R10: verdicts are mutually exclusive
  p_verdict_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_ok && frame_error));

  // R7: success pulse lasts one cycle and follows an accepted close marker
  p_ok_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> !frame_ok);
  p_ok_after_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> $past(in_valid && in_ready && in_data == 8'hA5));

  // R8: error pulse lasts one cycle
  p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_error |=> !frame_error);

  // R3: header strobe lasts one cycle
  p_hdr_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> !hdr_valid);

  // R4: no payload beat beyond the announced count
  p_beat_budget_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (hdr_valid || budget_q != '0));

  // R5: a stalled payload byte is not taken from upstream
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R10: announced count within 1..256
  p_count_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> (hdr_count >= 1 && hdr_count <= 256));
endmodule

bind frm_rx_top frm_rx_top_chk #(.CNT_W(9)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_data     (in_data),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .hdr_valid   (hdr_valid),
  .hdr_count   (hdr_count),
  .frame_ok    (frame_ok),
  .frame_error (frame_error)
);

// File: tb/frm_rx_top_tb_top.sv
`timescale 1ns/1ps
module frm_rx_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_ready = 1'b1;
  logic        hdr_valid;
  logic [7:0]  hdr_type;
  logic [23:0] hdr_addr;
  logic [8:0]  hdr_count;
  logic        frame_ok;
  logic        frame_error;

  int checks = 0;
  int errors = 0;
  int ok_seen = 0, err_seen = 0, hdr_seen = 0;
  logic [7:0]  cap_type;
  logic [23:0] cap_addr;
  logic [8:0]  cap_count;
  logic [7:0]  got[$];
  bit          stall_mode = 1'b0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  frm_rx_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .hdr_valid(hdr_valid), .hdr_type(hdr_type),
    .hdr_addr(hdr_addr), .hdr_count(hdr_count), .frame_ok(frame_ok),
    .frame_error(frame_error)
  );

  // pulse monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (frame_ok)    ok_seen++;
    if (frame_error) err_seen++;
    if (hdr_valid) begin
      hdr_seen++;
      cap_type  = hdr_type;
      cap_addr  = hdr_addr;
      cap_count = hdr_count;
    end
    out_ready <= stall_mode ? ~out_ready : 1'b1;
  end

  task automatic check(input bit cond, input string req, input longint act, input longint exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bitwise long division form of the CRC
  function automatic logic [7:0] ref_crc(input logic [7:0] msg[$]);
    logic [7:0] c = 8'h00;
    foreach (msg[i]) begin
      for (int b = 7; b >= 0; b--) begin
        logic fb;
        fb = c[7] ^ msg[i][b];
        c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
      end
    end
    return c;
  endfunction

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 3) + (i * 29) + (i >> 3));
  endfunction

  task automatic push_byte(input logic [7:0] b);
    bit taken = 1'b0;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!taken) begin
      #1;
      if (in_ready) begin
        if (out_valid) got.push_back(out_data);
        taken = 1'b1;
      end else begin
        @(negedge clk);
      end
    end
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // mode 0: good, 1: bad CRC, 2: bad close marker
  task automatic run_frame(input string tag, input logic [7:0] typ, input logic [23:0] addr,
                           input int n, input int seed, input int mode);
    logic [7:0] body[$];
    logic [7:0] exp_data[$];
    logic [7:0] crc;
    int ok0, err0, hdr0;
    ok0 = ok_seen; err0 = err_seen; hdr0 = hdr_seen;
    got.delete();
    body.push_back(typ);
    body.push_back(8'(n - 1));
    body.push_back(addr[23:16]);
    body.push_back(addr[15:8]);
    body.push_back(addr[7:0]);
    for (int i = 0; i < n; i++) begin
      body.push_back(pat(seed, i));
      exp_data.push_back(pat(seed, i));
    end
    crc = ref_crc(body);
    push_byte(8'h3C);
    foreach (body[i]) push_byte(body[i]);
    push_byte(mode == 1 ? ~crc : crc);
    if (mode == 1) begin
      @(negedge clk);
      check(frame_error === 1'b1, {tag, " R8 error pulse after CRC byte"}, frame_error, 1);
      push_byte(8'hA5);   // must be dropped while hunting
    end else begin
      push_byte(mode == 2 ? 8'h5A : 8'hA5);
      @(negedge clk);
      if (mode == 0)
        check(frame_ok === 1'b1, {tag, " R7 ok pulse after close"}, frame_ok, 1);
      else
        check(frame_error === 1'b1, {tag, " R9 error pulse after bad close"}, frame_error, 1);
    end
    @(negedge clk);
    check(!frame_ok && !frame_error, {tag, " R7 pulses are one cycle"}, {frame_ok, frame_error}, 0);
    repeat (2) @(negedge clk);
    check(hdr_seen - hdr0 == 1, {tag, " R3 one header strobe"}, hdr_seen - hdr0, 1);
    check(cap_type == typ, {tag, " R3 type"}, cap_type, typ);
    check(cap_addr == addr, {tag, " R3 address MSB first"}, cap_addr, addr);
    check(cap_count == 9'(n), {tag, " R4 count"}, cap_count, n);
    check(got.size() == n, {tag, " R4 payload length"}, got.size(), n);
    for (int i = 0; i < n && i < got.size(); i++)
      if (got[i] != exp_data[i]) begin
        check(1'b0, {tag, " R4 payload byte"}, got[i], exp_data[i]);
        break;
      end
    check(ok_seen - ok0 == (mode == 0 ? 1 : 0), {tag, " R6 ok count"}, ok_seen - ok0, mode == 0);
    check(err_seen - err0 == (mode == 0 ? 0 : 1), {tag, " R8 R9 error count"}, err_seen - err0, mode != 0);
  endtask

  task automatic t_reset();
    #1;
    check(in_ready === 1'b1, "R1 in_ready", in_ready, 1);
    check(out_valid === 1'b0, "R1 out_valid", out_valid, 0);
    check({hdr_valid, frame_ok, frame_error} === 3'b000, "R1 strobes idle",
          {hdr_valid, frame_ok, frame_error}, 0);
  endtask

  task automatic t_garbage();
    int ok0 = ok_seen, err0 = err_seen, hdr0 = hdr_seen;
    got.delete();
    push_byte(8'h00); push_byte(8'hA5); push_byte(8'hFF); push_byte(8'h3D);
    repeat (2) @(negedge clk);
    check(got.size() == 0, "R2 no payload from noise", got.size(), 0);
    check(ok_seen == ok0 && err_seen == err0 && hdr_seen == hdr0, "R2 no strobes from noise",
          ok_seen - ok0 + err_seen - err0 + hdr_seen - hdr0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_garbage();
    run_frame("short", 8'h11, 24'hABCDEF, 1, 5, 0);        // R10 minimum
    run_frame("mid", 8'h02, 24'h012345, 17, 9, 0);
    stall_mode = 1'b1;
    run_frame("stall R5", 8'h7E, 24'h800001, 23, 4, 0);
    stall_mode = 1'b0;
    run_frame("badcrc", 8'h03, 24'h000010, 6, 2, 1);
    run_frame("recover", 8'h04, 24'h00FF00, 3, 7, 0);
    run_frame("badclose", 8'h05, 24'hFEDCBA, 8, 3, 2);
    run_frame("max R10", 8'hC0, 24'h123456, 256, 11, 0);   // maximum
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule